// File: doc/BRIEF.md
# Double-Buffered DMA Channel

This block is one DMA channel that moves single beats of data between memory and a peripheral FIFO. It works through two buffer descriptors in alternation, buffer 0 and buffer 1. Each descriptor has a start address, a transfer count and four high address bits. Software loads one descriptor while the channel drains the other. When a buffer's count is used up, the channel marks that buffer done, turns its enable off and moves to the other buffer. It can also pulse an interrupt at that point.

Software reaches the channel through a small 32-bit register bank. The mode word is changed through two write ports. One port sets the bits written as 1 and the other clears them. Reading the set port returns the live mode word, which includes two status bits: the active buffer and the halt state. Each memory beat is presented on a request/acknowledge port. A beat may start only while the peripheral asserts its data-request input.

Top module: `pingpong_dma_chan`

## Requirements
- R1: After reset every mode bit and every descriptor and address register is zero, the active buffer is 0, `xfer_req` and `irq` are low, and a mode read returns 0x0000_0040 (only the halt bit set).
- R2: A register write to offset 0x00 sets every mode bit that is 1 in the data, and a write to offset 0x04 clears every mode bit that is 1 in the data. Writable bits are: 0 buffer-0 enable, 1 buffer-0 done, 2 buffer-1 enable, 3 buffer-1 done, 5 go, 7 interrupt enable, 8 non-coherent, 10:9 width code, 11 burst-of-8, 12 direction, 13 endian, 19:16 device id, 23:20 device-address high nibble. Bit 4 (active buffer) and bit 6 (halt) are read-only, and reading offset 0x04 or any unmapped offset returns 0.
- R3: The registers at offset 0x08 (device address), 0x0C (buffer-0 start) and 0x14 (buffer-1 start) hold 32 bits. The registers at offset 0x10 (buffer-0 count) and 0x18 (buffer-1 count) keep bits 19:0, holding the count in 15:0 and the high address nibble in 19:16, and they read 0 in bits 31:20.
- R4: A beat starts (`xfer_req` rises one cycle later) only while go is set, the active buffer is enabled, its count is non-zero and `periph_req` is high. `xfer_req` then stays high until `xfer_ack` is seen.
- R5: During a beat, `xfer_mem_addr` is the active buffer's high nibble above bits 27:0 of its start register. `xfer_dev_addr` is mode bits 23:20 above bits 27:0 of the device-address register. `xfer_dir` equals mode bit 12, and `xfer_bytes` is the beat size.
- R6: Each acknowledged beat decrements the active count by 1 and adds the beat size to the active start address. The beat size is 1, 2 or 4 bytes for width codes 0, 1 or 2, and code 3 is treated as 4 bytes.
- R7: When the channel is idle with go set, the active buffer enabled and its count at zero, the next edge sets that buffer's done bit, clears its enable bit and toggles the active-buffer bit.
- R8: A buffer completion drives `irq` high for one cycle, one cycle later, only if interrupt enable (bit 7) is set.
- R9: After a completion the channel carries on in the other buffer if that buffer is enabled. Otherwise it issues no beat until that buffer is enabled.
- R10: The halt bit reads 1 exactly when go is 0 and no beat is outstanding. A beat in flight when go is cleared still completes and updates its count, and no new beat starts while go is 0.
- R11: Writing a buffer's done bit to the clear port clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| periph_req | input | 1 | Peripheral ready for a datum |
| xfer_req | output | 1 | Beat outstanding |
| xfer_mem_addr | output | 32 | Memory byte address of the beat |
| xfer_dev_addr | output | 32 | Peripheral FIFO address |
| xfer_dir | output | 1 | Direction, copy of mode bit 12 |
| xfer_bytes | output | 3 | Beat size in bytes |
| xfer_ack | input | 1 | Beat accepted |
| irq | output | 1 | One-cycle buffer-done pulse |

## Verification
The assertions check the following on every cycle:
- an unacknowledged request is held;
- a request rises only after go and a peripheral request;
- every accepted beat takes exactly one from the active count;
- every completion toggles the active buffer;
- every interrupt follows a completion;
- no beat starts while go is low.

Other behaviour can only be shown by the scenarios: the exact addresses and beat sizes under each width code, the set and clear masks, the change from one buffer to the other with and without the second buffer enabled, and the halt bit staying low until a held beat is acknowledged.

// File: rtl/ppdma_pkg.sv
package ppdma_pkg;
  localparam int REG_W  = 32;
  localparam int REG_AW = 8;
  localparam int CNT_W  = 16;
  localparam int HI_W   = 4;
  localparam int LO_W   = REG_W - HI_W;
  localparam int NBUF   = 2;

  localparam logic [REG_AW-1:0] OFS_MODE_SET = 8'h00;
  localparam logic [REG_AW-1:0] OFS_MODE_CLR = 8'h04;
  localparam logic [REG_AW-1:0] OFS_DEV_ADDR = 8'h08;

  localparam int MB_EN0    = 0;
  localparam int MB_DN0    = 1;
  localparam int MB_EN1    = 2;
  localparam int MB_DN1    = 3;
  localparam int MB_ACT    = 4;
  localparam int MB_GO     = 5;
  localparam int MB_HALT   = 6;
  localparam int MB_IE     = 7;
  localparam int MB_WID_LO = 9;
  localparam int MB_DIR    = 12;
  localparam int MB_DHI_LO = 20;

  localparam logic [REG_W-1:0] MODE_WR_MASK = 32'h00FF_3FAF;
  localparam logic [REG_W-1:0] LO_MASK      = {{HI_W{1'b0}}, {LO_W{1'b1}}};

  function automatic logic [REG_AW-1:0] start_ofs(input int b);
    return REG_AW'(8'h0C + 8 * b);
  endfunction

  function automatic logic [REG_AW-1:0] count_ofs(input int b);
    return REG_AW'(8'h10 + 8 * b);
  endfunction

  // Beat size in bytes for a width code; code 3 behaves as 32-bit.
  function automatic logic [2:0] beat_bytes(input logic [1:0] wcode);
    case (wcode)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] join_addr(input logic [HI_W-1:0] hi,
                                                 input logic [REG_W-1:0] base);
    return (base & LO_MASK) | {hi, {LO_W{1'b0}}};
  endfunction
endpackage

// File: rtl/ppdma_buf_desc.sv
module ppdma_buf_desc
  import ppdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_start,
  input  logic             wr_count,
  input  logic [REG_W-1:0] wdata,
  input  logic             step,
  input  logic [2:0]       step_bytes,
  output logic [REG_W-1:0] start_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [HI_W-1:0]  hi_q
);
  // Software writes take priority over the engine's per-beat update.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
      hi_q    <= '0;
    end else begin
      if (wr_start)  start_q <= wdata;
      else if (step) start_q <= start_q + REG_W'(step_bytes);
      if (wr_count) begin
        cnt_q <= wdata[CNT_W-1:0];
        hi_q  <= wdata[CNT_W +: HI_W];
      end else if (step) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ppdma_mode_reg.sv
module ppdma_mode_reg
  import ppdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [REG_W-1:0] wdata,
  input  logic             finish,
  output logic [REG_W-1:0] mode_q,
  output logic             act_q
);
  logic [REG_W-1:0] mode_nxt;

  // Set, then clear, then the engine's completion update on top.
  always_comb begin
    mode_nxt = mode_q;
    if (wr_set) mode_nxt = mode_nxt | (wdata & MODE_WR_MASK);
    if (wr_clr) mode_nxt = mode_nxt & ~(wdata & MODE_WR_MASK);
    if (finish) begin
      if (act_q) begin
        mode_nxt[MB_DN1] = 1'b1;
        mode_nxt[MB_EN1] = 1'b0;
      end else begin
        mode_nxt[MB_DN0] = 1'b1;
        mode_nxt[MB_EN0] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      act_q  <= 1'b0;
    end else begin
      mode_q <= mode_nxt;
      if (finish) act_q <= ~act_q;
    end
  end
endmodule

// File: rtl/ppdma_beat_ctl.sv
module ppdma_beat_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic en_act,
  input  logic cnt_zero,
  input  logic ie,
  input  logic periph_req,
  input  logic xfer_ack,
  output logic busy_q,
  output logic beat_start,
  output logic beat_done,
  output logic buf_finish,
  output logic irq_q
);
  logic ready;

  assign ready      = !busy_q && go && en_act;
  assign beat_start = ready && !cnt_zero && periph_req;
  assign buf_finish = ready && cnt_zero;
  assign beat_done  = busy_q && xfer_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (beat_start)     busy_q <= 1'b1;
      else if (beat_done) busy_q <= 1'b0;
      irq_q <= buf_finish && ie;
    end
  end
endmodule

// File: rtl/pingpong_dma_chan.sv
module pingpong_dma_chan
  import ppdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              periph_req,
  output logic              xfer_req,
  output logic [REG_W-1:0]  xfer_mem_addr,
  output logic [REG_W-1:0]  xfer_dev_addr,
  output logic              xfer_dir,
  output logic [2:0]        xfer_bytes,
  input  logic              xfer_ack,
  output logic              irq
);
  logic [REG_W-1:0] mode_q;
  logic [REG_W-1:0] mode_view;
  logic [REG_W-1:0] dev_addr_q;
  logic             act;
  logic             go;
  logic             halt;
  logic             busy;
  logic             en_act;
  logic             cnt_zero;
  logic             beat_start;
  logic             beat_done;
  logic             buf_finish;
  logic [2:0]       step_bytes;
  logic             wr_set;
  logic             wr_clr;

  logic [REG_W-1:0] start_q [NBUF];
  logic [CNT_W-1:0] cnt_q   [NBUF];
  logic [HI_W-1:0]  hi_q    [NBUF];

  assign wr_set     = reg_wr && (reg_addr == OFS_MODE_SET);
  assign wr_clr     = reg_wr && (reg_addr == OFS_MODE_CLR);
  assign go         = mode_q[MB_GO];
  assign en_act     = act ? mode_q[MB_EN1] : mode_q[MB_EN0];
  assign cnt_zero   = (cnt_q[act] == '0);
  assign step_bytes = beat_bytes(mode_q[MB_WID_LO +: 2]);
  assign halt       = !go && !busy;

  ppdma_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_set (wr_set),
    .wr_clr (wr_clr),
    .wdata  (reg_wdata),
    .finish (buf_finish),
    .mode_q (mode_q),
    .act_q  (act)
  );

  ppdma_beat_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .en_act     (en_act),
    .cnt_zero   (cnt_zero),
    .ie         (mode_q[MB_IE]),
    .periph_req (periph_req),
    .xfer_ack   (xfer_ack),
    .busy_q     (busy),
    .beat_start (beat_start),
    .beat_done  (beat_done),
    .buf_finish (buf_finish),
    .irq_q      (irq)
  );

  for (genvar b = 0; b < NBUF; b++) begin : g_desc
    logic wr_s, wr_c, stp;
    assign wr_s = reg_wr && (reg_addr == start_ofs(b));
    assign wr_c = reg_wr && (reg_addr == count_ofs(b));
    assign stp  = beat_done && (act == 1'(b));
    ppdma_buf_desc u_desc (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_start   (wr_s),
      .wr_count   (wr_c),
      .wdata      (reg_wdata),
      .step       (stp),
      .step_bytes (step_bytes),
      .start_q    (start_q[b]),
      .cnt_q      (cnt_q[b]),
      .hi_q       (hi_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                dev_addr_q <= '0;
    else if (reg_wr && reg_addr == OFS_DEV_ADDR) dev_addr_q <= reg_wdata;
  end

  always_comb begin
    mode_view          = mode_q;
    mode_view[MB_ACT]  = act;
    mode_view[MB_HALT] = halt;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_MODE_SET) reg_rdata = mode_view;
    if (reg_addr == OFS_DEV_ADDR) reg_rdata = dev_addr_q;
    for (int b = 0; b < NBUF; b++) begin
      if (reg_addr == start_ofs(b)) reg_rdata = start_q[b];
      if (reg_addr == count_ofs(b)) reg_rdata = REG_W'({hi_q[b], cnt_q[b]});
    end
  end

  assign xfer_req      = busy;
  assign xfer_mem_addr = join_addr(hi_q[act], start_q[act]);
  assign xfer_dev_addr = join_addr(mode_q[MB_DHI_LO +: HI_W], dev_addr_q);
  assign xfer_dir      = mode_q[MB_DIR];
  assign xfer_bytes    = step_bytes;
endmodule

// File: rtl/ppdma_chk.sv
module ppdma_chk
  import ppdma_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             periph_req,
  input logic             xfer_req,
  input logic             xfer_ack,
  input logic             irq,
  input logic             go,
  input logic             act,
  input logic             buf_finish,
  input logic             beat_done,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1
);
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> xfer_req);

  a_r4_rise_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_req) |-> ($past(go) && $past(periph_req)));

  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !reg_wr) |=> ((act ? cnt1 : cnt0) == $past(act ? cnt1 : cnt0) - CNT_W'(1)));

  a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    buf_finish |=> (act != $past(act)));

  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(buf_finish));

  a_r10_no_beat_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !xfer_req) |=> !xfer_req);
endmodule

bind pingpong_dma_chan ppdma_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .periph_req (periph_req),
  .xfer_req   (xfer_req),
  .xfer_ack   (xfer_ack),
  .irq        (irq),
  .go         (go),
  .act        (act),
  .buf_finish (buf_finish),
  .beat_done  (beat_done),
  .cnt0       (cnt_q[0]),
  .cnt1       (cnt_q[1])
);

// File: tb/pingpong_dma_chan_tb_top.sv
`timescale 1ns/1ps
module pingpong_dma_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        periph_req;
  logic        xfer_req;
  logic [31:0] xfer_mem_addr;
  logic [31:0] xfer_dev_addr;
  logic        xfer_dir;
  logic [2:0]  xfer_bytes;
  logic        xfer_ack;
  logic        irq;

  always #4 clk = ~clk;

  pingpong_dma_chan dut_i (.*);

  typedef struct packed {
    logic [31:0] mem;
    logic [31:0] dev;
    logic        dir;
    logic [2:0]  nbytes;
  } beat_t;

  beat_t exp_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  int    irq_seen = 0;
  int    beats_seen = 0;
  bit    hold_ack = 1'b0;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic push_beat(input logic [31:0] mem, input logic [31:0] dev,
                           input logic dir, input logic [2:0] nb);
    beat_t b;
    b.mem = mem; b.dev = dev; b.dir = dir; b.nbytes = nb;
    exp_q.push_back(b);
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (6) @(negedge clk);
    check(req, 32'(exp_q.size()), 32'd0);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Monitor: pops expected beats, compares, acknowledges, counts irq pulses.
  initial begin
    xfer_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n !== 1'b1) begin
        xfer_ack = 1'b0;
      end else if (xfer_ack) begin
        xfer_ack = 1'b0;
      end else if (xfer_req && !hold_ack) begin
        beats_seen++;
        if (exp_q.size() == 0) begin
          check("R4 unexpected beat", xfer_mem_addr, 32'hFFFF_FFFF);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          check("R5/R6 mem addr", xfer_mem_addr, e.mem);
          check("R5 dev addr", xfer_dev_addr, e.dev);
          check("R5 dir", 32'(xfer_dir), 32'(e.dir));
          check("R5 bytes", 32'(xfer_bytes), 32'(e.nbytes));
        end
        xfer_ack = 1'b1;
      end
      if (rst_n === 1'b1 && irq === 1'b1) irq_seen++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int irq_base;
    int beats_base;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; periph_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_check("R1 mode", 8'h00, 32'h0000_0040);
    rd_check("R1 count0", 8'h10, 32'h0);
    rd_check("R1 start0", 8'h0C, 32'h0);
    check("R1 xfer_req", 32'(xfer_req), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);

    // R2 set/clear ports, read-only bits
    wr(8'h00, 32'hFFFF_FFDF);
    rd_check("R2 set mask", 8'h00, 32'h00FF_3FCF);
    wr(8'h04, 32'h0000_3F00);
    rd_check("R2 partial clear", 8'h00, 32'h00FF_00CF);
    wr(8'h04, 32'hFFFF_FFFF);
    rd_check("R2 full clear", 8'h00, 32'h0000_0040);
    rd_check("R2 clear port reads 0", 8'h04, 32'h0);

    // R3 descriptor registers
    wr(8'h08, 32'hA123_4567);
    rd_check("R3 dev addr", 8'h08, 32'hA123_4567);
    wr(8'h10, 32'hFFFF_FFFF);
    rd_check("R3 count field", 8'h10, 32'h000F_FFFF);
    wr(8'h0C, 32'h1234_5678);
    rd_check("R3 start0", 8'h0C, 32'h1234_5678);

    // Scenario A: 32-bit, both buffers, interrupts on (R5 R6 R7 R8 R9)
    wr(8'h08, 32'h0000_1000);
    wr(8'h0C, 32'h0000_0100);
    wr(8'h10, 32'h0002_0003);
    wr(8'h14, 32'h0000_0800);
    wr(8'h18, 32'h0003_0002);
    wr(8'h00, 32'h0050_1485);
    push_beat(32'h2000_0100, 32'h5000_1000, 1'b1, 3'd4);
    push_beat(32'h2000_0104, 32'h5000_1000, 1'b1, 3'd4);
    push_beat(32'h2000_0108, 32'h5000_1000, 1'b1, 3'd4);
    push_beat(32'h3000_0800, 32'h5000_1000, 1'b1, 3'd4);
    push_beat(32'h3000_0804, 32'h5000_1000, 1'b1, 3'd4);
    periph_req = 1'b1;
    wr(8'h00, 32'h0000_0020);
    drain("R9 ping-pong beats drained");
    check("R8 irq count with IE", 32'(irq_seen), 32'd2);
    rd_check("R7 mode after both buffers", 8'h00, 32'h0050_14AA);
    rd_check("R6 count0 exhausted", 8'h10, 32'h0002_0000);
    rd_check("R6 start0 advanced by 4", 8'h0C, 32'h0000_010C);
    rd_check("R6 start1 advanced by 4", 8'h14, 32'h0000_0808);

    // Scenario B: 16-bit, IE off, buffer 1 enabled late (R7 R8 R9)
    wr(8'h04, 32'hFFFF_FFFF);
    irq_base = irq_seen;
    wr(8'h0C, 32'h0000_0200);
    wr(8'h10, 32'h0000_0002);
    wr(8'h00, 32'h0000_0201);
    push_beat(32'h0000_0200, 32'h0000_1000, 1'b0, 3'd2);
    push_beat(32'h0000_0202, 32'h0000_1000, 1'b0, 3'd2);
    wr(8'h00, 32'h0000_0020);
    drain("R6 16-bit beats drained");
    rd_check("R7 done0 set, act toggled", 8'h00, 32'h0000_0232);
    beats_base = beats_seen;
    repeat (10) @(negedge clk);
    check("R9 idle while buffer1 disabled", 32'(beats_seen), 32'(beats_base));
    check("R9 no request while idle", 32'(xfer_req), 32'd0);
    check("R8 no irq with IE clear", 32'(irq_seen), 32'(irq_base));
    wr(8'h14, 32'h0000_0300);
    wr(8'h18, 32'h0000_0001);
    push_beat(32'h0000_0300, 32'h0000_1000, 1'b0, 3'd2);
    wr(8'h00, 32'h0000_0004);
    drain("R9 resume in buffer1");
    rd_check("R7 both done, act back to 0", 8'h00, 32'h0000_022A);
    rd_check("R6 start0 advanced by 2", 8'h0C, 32'h0000_0204);

    // Scenario C: 8-bit, then done clear (R6 R11)
    wr(8'h04, 32'h0000_060A);
    wr(8'h0C, 32'h0000_0010);
    wr(8'h10, 32'h0000_0002);
    push_beat(32'h0000_0010, 32'h0000_1000, 1'b0, 3'd1);
    push_beat(32'h0000_0011, 32'h0000_1000, 1'b0, 3'd1);
    wr(8'h00, 32'h0000_0001);
    drain("R6 8-bit beats drained");
    rd_check("R7 8-bit completion", 8'h00, 32'h0000_0032);
    wr(8'h04, 32'h0000_0002);
    rd_check("R11 done0 cleared", 8'h00, 32'h0000_0030);

    // Scenario D: request gating and halt with a beat in flight (R4 R10)
    wr(8'h04, 32'h0000_0020);
    rd_check("R10 halt when stopped", 8'h00, 32'h0000_0050);
    periph_req = 1'b0;
    wr(8'h14, 32'h0000_0400);
    wr(8'h18, 32'h0000_0005);
    wr(8'h00, 32'h0000_0404);
    beats_base = beats_seen;
    wr(8'h00, 32'h0000_0020);
    repeat (8) @(negedge clk);
    check("R4 no beat without periph_req", 32'(xfer_req), 32'd0);
    hold_ack = 1'b1;
    push_beat(32'h0000_0400, 32'h0000_1000, 1'b0, 3'd4);
    periph_req = 1'b1;
    repeat (4) @(negedge clk);
    check("R4 request held until ack", 32'(xfer_req), 32'd1);
    periph_req = 1'b0;
    wr(8'h04, 32'h0000_0020);
    rd_check("R10 no halt while beat in flight", 8'h00, 32'h0000_0414);
    hold_ack = 1'b0;
    repeat (4) @(negedge clk);
    rd_check("R10 halt after in-flight beat", 8'h00, 32'h0000_0454);
    rd_check("R10 in-flight beat counted", 8'h18, 32'h0000_0004);
    check("R10 queue empty", 32'(exp_q.size()), 32'd0);
    periph_req = 1'b1;
    repeat (6) @(negedge clk);
    check("R10 no beat while go clear", 32'(xfer_req), 32'd0);
    check("R10 beat total", 32'(beats_seen - beats_base), 32'd1);

    summary();
  end
endmodule